// File: doc/BRIEF.md
# Receive Byte Buffer with Hysteresis Flow Control

This block sits between a serial receiver and a consumer that drains data more slowly than it can arrive. Received bytes are written into a power-of-two circular store. The consumer pulls them out in arrival order over a valid/ready port. An occupancy count drives a ready-to-receive line, `rts`. The line drops once the fill level climbs past an upper mark. It comes back only after the fill level has fallen under a separate lower mark, so it does not chatter near a single threshold.

The upper mark must leave at least 16 free slots, because a remote sender with a 16-byte transmit queue may keep transmitting after the line falls. A parameter check rejects any configuration that breaks this margin. It also rejects a depth that is not a power of two and a lower mark that is not below the upper mark.

When the software flow option is enabled, each change of the line also raises a request to a transmitter to send a pause or resume character. A later change overwrites a request that has not yet been taken. A byte that arrives while the store is full is discarded, and a sticky flag records the loss until software clears it.

Top module: `rx_watermark_buf`

## Requirements
- R1: After reset the store is empty (`rd_valid` low), `rts` is high, `sfc_valid` is low and `overrun` is low.
- R2: Bytes come out on `rd_data` in the order they were accepted, including across the wrap of the indices. `rd_valid` is high exactly when at least one byte is held, and the store never holds more than DEPTH bytes.
- R3: When the held count becomes greater than HI_MARK (default 48 of 64), `rts` goes low on the following clock edge. A count equal to HI_MARK leaves `rts` high.
- R4: When `rts` is low and the held count becomes less than LO_MARK (default 16), `rts` returns high on the following clock edge. A count between the two marks keeps `rts` at its previous level.
- R5: With SW_FLOW_EN set, every change of `rts` raises `sfc_valid` on the same edge. `sfc_code` carries 8'h13 (pause) when `rts` falls and 8'h11 (resume) when it rises.
- R6: A raised request stays valid, with a stable code, until a cycle with `sfc_ready` high. A newer `rts` change replaces a request that has not been taken.
- R7: A write while DEPTH bytes are held is discarded and sets `overrun`. The flag stays set until `overrun_clr` is high for a cycle; a new loss in the same cycle wins over the clear.
- R8: A write and a read in the same cycle deliver the head byte, store the new byte and leave the held count unchanged.
- R9: A read request while the store is empty delivers nothing and does not advance the read position; the next byte written is the next byte read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Receiver presents a byte this cycle |
| wr_data | input | DW | Received byte |
| rd_valid | output | 1 | A byte is available at the head |
| rd_data | output | DW | Head byte |
| rd_ready | input | 1 | Consumer takes the head byte |
| rts | output | 1 | High when the remote sender may transmit |
| sfc_valid | output | 1 | Pause/resume character requested |
| sfc_code | output | 8 | Character to send: 8'h13 pause, 8'h11 resume |
| sfc_ready | input | 1 | Transmitter takes the request |
| overrun | output | 1 | Sticky: a byte was lost to a full store |
| overrun_clr | input | 1 | Clears the overrun flag |

## Verification
A corrupted occupancy count shows up at the ports as an `rts` edge at the wrong fill level, one cycle after the bad count forms. It also shows up as `rd_valid` staying high past the last byte, or dropping while bytes are still owed. A misplaced index shows up on the very next read as a byte out of order or a repeated byte. A lost or stale request register shows up as `sfc_valid` falling without a handshake, or as the wrong character after an overwrite. Each directed scenario therefore steps the fill level one byte at a time across each mark, and it compares every delivered byte against an arrival-order model.

// File: rtl/rxwm_pkg.sv
package rxwm_pkg;
   localparam logic [7:0] CHAR_RESUME = 8'h11;
   localparam logic [7:0] CHAR_PAUSE  = 8'h13;
   localparam int unsigned SENDER_SLACK = 16;
endpackage

// File: rtl/rxwm_ring.sv
module rxwm_ring #(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned DW    = 8,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   input  logic          pop,
   output logic [DW-1:0] head_data,
   output logic          nonempty,
   output logic          is_full,
   output logic [CW-1:0] level
);
   logic [DW-1:0] store [DEPTH];
   logic [AW-1:0] put_ix, get_ix;
   logic [CW-1:0] held;
   logic          put_ok, get_ok;

   assign is_full  = (held == CW'(DEPTH));
   assign nonempty = (held != '0);
   assign put_ok   = push && !is_full;
   assign get_ok   = pop && nonempty;
   assign head_data = store[get_ix];
   assign level    = held;

   always_ff @(posedge clk) begin
      if (put_ok) store[put_ix] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         put_ix <= '0;
         get_ix <= '0;
         held   <= '0;
      end else begin
         if (put_ok) put_ix <= put_ix + 1'b1;
         if (get_ok) get_ix <= get_ix + 1'b1;
         unique case ({put_ok, get_ok})
            2'b10:   held <= held + 1'b1;
            2'b01:   held <= held - 1'b1;
            default: held <= held;
         endcase
      end
   end

   // R2
   held_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      held <= CW'(DEPTH));
   // R7
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_full && !pop) |=> (held == CW'(DEPTH)));
   // R9
   empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!nonempty) |=> (get_ix == $past(get_ix)));
   // R8
   both_ways_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop && nonempty && !is_full) |=> $stable(held));
endmodule

// File: rtl/rxwm_flow.sv
module rxwm_flow #(
   parameter int unsigned CW      = 7,
   parameter int unsigned HI_MARK = 48,
   parameter int unsigned LO_MARK = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] level,
   output logic          permit,
   output logic          go_block,
   output logic          go_release
);
   logic permit_q;

   assign go_block   = permit_q && (level > CW'(HI_MARK));
   assign go_release = !permit_q && (level < CW'(LO_MARK));
   assign permit     = permit_q;

   always_ff @(posedge clk) begin
      if (!rst_n)          permit_q <= 1'b1;
      else if (go_block)   permit_q <= 1'b0;
      else if (go_release) permit_q <= 1'b1;
   end

   // R4
   band_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (level >= CW'(LO_MARK) && level <= CW'(HI_MARK)) |=> $stable(permit_q));
   // R3
   high_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (level > CW'(HI_MARK)) |=> !permit_q);
endmodule

// File: rtl/rxwm_swreq.sv
module rxwm_swreq
   import rxwm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go_block,
   input  logic       go_release,
   output logic       req_valid,
   output logic [7:0] req_code,
   input  logic       req_ready
);
   logic       pend;
   logic [7:0] code_q;

   assign req_valid = pend;
   assign req_code  = code_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend   <= 1'b0;
         code_q <= CHAR_RESUME;
      end else if (go_block || go_release) begin
         pend   <= 1'b1;
         code_q <= go_block ? CHAR_PAUSE : CHAR_RESUME;
      end else if (req_ready) begin
         pend   <= 1'b0;
      end
   end

   // R6
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !req_ready && !go_block && !go_release) |=> (pend && $stable(code_q)));
   // R5
   req_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go_block |=> (pend && code_q == CHAR_PAUSE));
endmodule

// File: rtl/rx_watermark_buf.sv
module rx_watermark_buf
   import rxwm_pkg::*;
#(
   parameter int unsigned DEPTH      = 64,
   parameter int unsigned DW         = 8,
   parameter int unsigned HI_MARK    = (DEPTH * 3) / 4,
   parameter int unsigned LO_MARK    = DEPTH / 4,
   parameter bit          SW_FLOW_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_valid,
   input  logic [DW-1:0] wr_data,
   output logic          rd_valid,
   output logic [DW-1:0] rd_data,
   input  logic          rd_ready,
   output logic          rts,
   output logic          sfc_valid,
   output logic [7:0]    sfc_code,
   input  logic          sfc_ready,
   output logic          overrun,
   input  logic          overrun_clr
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned CW = AW + 1;

   initial begin
      depth_pow2_chk: assert ((1 << AW) == DEPTH)
         else $error("DEPTH must be a power of two");
      slack_chk: assert (DEPTH >= HI_MARK + SENDER_SLACK)
         else $error("HI_MARK leaves too little headroom");
      marks_order_chk: assert (LO_MARK < HI_MARK)
         else $error("LO_MARK must be below HI_MARK");
   end

   logic          full;
   logic [CW-1:0] level;
   logic          go_block, go_release;
   logic          lost_q;

   rxwm_ring #(.DEPTH(DEPTH), .DW(DW)) u_ring (
      .clk(clk), .rst_n(rst_n),
      .push(wr_valid), .push_data(wr_data),
      .pop(rd_ready), .head_data(rd_data),
      .nonempty(rd_valid), .is_full(full), .level(level)
   );

   rxwm_flow #(.CW(CW), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK)) u_flow (
      .clk(clk), .rst_n(rst_n), .level(level),
      .permit(rts), .go_block(go_block), .go_release(go_release)
   );

   generate
      if (SW_FLOW_EN) begin : g_sw
         rxwm_swreq u_req (
            .clk(clk), .rst_n(rst_n),
            .go_block(go_block), .go_release(go_release),
            .req_valid(sfc_valid), .req_code(sfc_code), .req_ready(sfc_ready)
         );
      end else begin : g_nosw
         assign sfc_valid = 1'b0;
         assign sfc_code  = 8'h00;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)                 lost_q <= 1'b0;
      else if (wr_valid && full)  lost_q <= 1'b1;
      else if (overrun_clr)       lost_q <= 1'b0;
   end
   assign overrun = lost_q;

   // R7
   lost_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lost_q && !overrun_clr) |=> lost_q);
   // R7
   lost_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && full) |=> lost_q);
endmodule

// File: tb/sim_rx_watermark_buf.sv
module sim_rx_watermark_buf;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_valid = 1'b0, rd_ready = 1'b0, sfc_ready = 1'b0, overrun_clr = 1'b0;
   logic [7:0] wr_data = '0;
   logic rd_valid, rts, sfc_valid, overrun;
   logic [7:0] rd_data, sfc_code;
   logic [7:0] model[$];
   int checks = 0, fails = 0;
   bit done = 0;

   always #2 clk = ~clk;

   rx_watermark_buf u0 (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
      .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready), .rts(rts),
      .sfc_valid(sfc_valid), .sfc_code(sfc_code), .sfc_ready(sfc_ready),
      .overrun(overrun), .overrun_clr(overrun_clr)
   );

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic push(input logic [7:0] b);
      wr_valid = 1'b1; wr_data = b;
      if (model.size() < 64) model.push_back(b);
      tick();
      wr_valid = 1'b0;
   endtask

   task automatic pop();
      check("R2 rd_valid", rd_valid, 1);
      check("R2 order", rd_data, model[0]);
      void'(model.pop_front());
      rd_ready = 1'b1;
      tick();
      rd_ready = 1'b0;
   endtask

   task automatic accept_req();
      sfc_ready = 1'b1; tick(); sfc_ready = 1'b0;
      check("R6 taken", sfc_valid, 0);
   endtask

   task automatic t_reset();
      check("R1 rd_valid", rd_valid, 0);
      check("R1 rts", rts, 1);
      check("R1 sfc_valid", sfc_valid, 0);
      check("R1 overrun", overrun, 0);
   endtask

   task automatic t_rise_and_block();
      for (int i = 0; i < 48; i++) push(8'(i * 7 + 3));
      tick();
      check("R3 at mark", rts, 1);
      push(8'hC4);
      check("R3 latency", rts, 1);
      tick();
      check("R3 dropped", rts, 0);
      check("R5 pause valid", sfc_valid, 1);
      check("R5 pause code", sfc_code, 8'h13);
      tick();
      check("R6 held", sfc_valid, 1);
      accept_req();
   endtask

   task automatic t_drain_release();
      while (model.size() > 16) pop();
      tick();
      check("R4 band", rts, 0);
      pop();
      tick();
      check("R4 raised", rts, 1);
      check("R5 resume valid", sfc_valid, 1);
      check("R5 resume code", sfc_code, 8'h11);
      accept_req();
      while (model.size() > 0) pop();
      check("R2 empty", rd_valid, 0);
   endtask

   task automatic t_empty_read();
      rd_ready = 1'b1; tick(); rd_ready = 1'b0;
      check("R9 none", rd_valid, 0);
      push(8'hA5);
      check("R9 next", rd_data, 8'hA5);
      pop();
      check("R9 empty", rd_valid, 0);
   endtask

   task automatic t_same_cycle();
      push(8'h31); push(8'h32); push(8'h33);
      check("R8 head", rd_data, 8'h31);
      wr_valid = 1'b1; wr_data = 8'h34; rd_ready = 1'b1;
      void'(model.pop_front()); model.push_back(8'h34);
      tick();
      wr_valid = 1'b0; rd_ready = 1'b0;
      pop(); pop(); pop();
      check("R8 count", rd_valid, 0);
   endtask

   task automatic t_overrun_replace();
      for (int i = 0; i < 64; i++) push(8'(255 - i));
      tick();
      check("R7 no loss yet", overrun, 0);
      check("R6 pause pending", sfc_code, 8'h13);
      push(8'hEE);
      check("R7 set", overrun, 1);
      check("R6 still pending", sfc_valid, 1);
      while (model.size() > 16) pop();
      pop();
      tick();
      check("R6 replaced valid", sfc_valid, 1);
      check("R6 replaced code", sfc_code, 8'h11);
      while (model.size() > 0) pop();
      check("R7 sticky", overrun, 1);
      check("R2 drained", rd_valid, 0);
      overrun_clr = 1'b1; tick(); overrun_clr = 1'b0;
      check("R7 cleared", overrun, 0);
      accept_req();
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_rise_and_block();
      t_drain_release();
      t_empty_read();
      t_same_cycle();
      t_overrun_replace();
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule